// File: doc/BRIEF.md
# TCM DMA Access Multiplexer

This block sits in front of a single-port SRAM used as tightly-coupled memory. Two requesters share the port: the processor's TCM controller, which has the timing-critical path, and an external DMA engine. When the DMA enable input is high, the DMA's address, chip select and write enable go straight to the memory and the sequential hint is held low. When the enable is low, the core controller's request passes through.

If the core raises a request while the DMA owns the port, the block captures that request's address and write enable. It raises a wait to the core from the next cycle on. The captured request goes to the memory in the first cycle the DMA lets go, and the wait drops one cycle later. After any real DMA access, meaning one with its chip select high, a force-non-sequential flag tells the core that its next access must restart as non-sequential. The flag stays up until a core access reaches the memory.

A DMA enable without a DMA chip select is legal only while the core controller reports itself idle. The block flags any cycle that breaks this rule, and no memory access takes place in such a cycle.

Top module: `tcm_dma_port_mux`

## Requirements
- R1: After reset, mem_cs, core_wait and force_nseq are all low.
- R2: While dma_en is high, mem_addr equals dma_addr, mem_cs equals dma_cs, and mem_we equals dma_we AND dma_cs.
- R3: While dma_en is high, mem_seq is low.
- R4: dma_illegal is high exactly in cycles where dma_en is high, dma_cs is low and core_idle is low. In such a cycle mem_cs is low.
- R5: A core request (core_req high) seen while dma_en is high and core_wait is low makes core_wait high in the next cycle. core_wait then stays high for every following cycle in which dma_en is still high.
- R6: In the first cycle with dma_en low while core_wait is high, the memory receives the captured request: mem_cs high, the captured address and write enable, and mem_seq low. The live core inputs have no effect in that cycle. core_wait is low in the following cycle.
- R7: While dma_en is low and core_wait is low, mem_cs equals core_req, mem_addr equals core_addr, and mem_we equals core_we AND core_req.
- R8: force_nseq goes high in the cycle after a cycle with dma_en and dma_cs both high. It stays high until a core access has been issued to the memory, and goes low in the cycle after that access.
- R9: A core access issued while force_nseq is high has mem_seq low. When force_nseq is low, a live core access carries core_seq onto mem_seq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_req | input | 1 | Core controller access request (chip select) |
| core_addr | input | 18 | Core word address |
| core_we | input | 1 | Core write enable |
| core_seq | input | 1 | Core sequential-access hint |
| core_idle | input | 1 | Core controller idle flag |
| core_wait | output | 1 | Wait to the core, pipelined by one cycle |
| force_nseq | output | 1 | Core's next access must be non-sequential |
| dma_en | input | 1 | DMA takes the memory port |
| dma_cs | input | 1 | DMA chip select |
| dma_addr | input | 18 | DMA word address |
| dma_we | input | 1 | DMA write enable |
| dma_illegal | output | 1 | DMA enabled without chip select while core busy |
| mem_cs | output | 1 | Memory chip select |
| mem_addr | output | 18 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_seq | output | 1 | Memory sequential-access hint |

## Verification
The hardest case to reach is a core request that arrives while the DMA holds the port, is then kept through several more DMA cycles, and is issued while the live core inputs show unrelated values. The flag from an earlier DMA access also has to still be pending at that moment. The stimulus reaches this case by sweeping all 64 combinations of the six single-bit controls over many rounds, with fresh addresses each time, so that DMA bursts of varying length cut across pending core requests. A directed sequence adds the illegal enable-without-select case while the core is busy.

// File: rtl/tcm_dma_pkg.sv
package tcm_dma_pkg;
    // Who owns the memory port, as seen from the registered state
    typedef enum logic [1:0] {
        OWN_CORE  = 2'd0,   // core passes through live
        OWN_DMA   = 2'd1,   // DMA held the port, nothing pending from core
        CORE_HELD = 2'd2    // core request captured and waiting
    } port_own_e;
endpackage

// File: rtl/tcm_port_fsm.sv
module tcm_port_fsm
    import tcm_dma_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dma_en,
    input  logic          core_req,
    input  logic [AW-1:0] core_addr,
    input  logic          core_we,
    output port_own_e     state,
    output logic [AW-1:0] held_addr,
    output logic          held_we
);
    port_own_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OWN_CORE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = OWN_CORE;
        unique case (state)
            OWN_CORE, OWN_DMA: begin
                if (dma_en && core_req) state_nx = CORE_HELD;
                else if (dma_en)        state_nx = OWN_DMA;
                else                    state_nx = OWN_CORE;
            end
            CORE_HELD: begin
                if (dma_en) state_nx = CORE_HELD;
                else        state_nx = OWN_CORE;
            end
            default: state_nx = OWN_CORE;
        endcase
    end

    // Capture the stalled core request on entry to CORE_HELD
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_addr <= '0;
            held_we   <= 1'b0;
        end else if (state != CORE_HELD && dma_en && core_req) begin
            held_addr <= core_addr;
            held_we   <= core_we;
        end
    end
endmodule

// File: rtl/tcm_port_select.sv
module tcm_port_select
    import tcm_dma_pkg::*;
#(
    parameter int AW = 18
) (
    input  port_own_e     state,
    input  logic          dma_en,
    input  logic          dma_cs,
    input  logic [AW-1:0] dma_addr,
    input  logic          dma_we,
    input  logic          core_req,
    input  logic [AW-1:0] core_addr,
    input  logic          core_we,
    input  logic          core_seq,
    input  logic [AW-1:0] held_addr,
    input  logic          held_we,
    input  logic          nseq_flag,
    output logic          mem_cs,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_seq,
    output logic          core_issue
);
    always_comb begin
        mem_cs     = 1'b0;
        mem_addr   = core_addr;
        mem_we     = 1'b0;
        mem_seq    = 1'b0;
        core_issue = 1'b0;
        if (dma_en) begin
            mem_cs   = dma_cs;
            mem_addr = dma_addr;
            mem_we   = dma_we & dma_cs;
            mem_seq  = 1'b0;
        end else begin
            unique case (state)
                CORE_HELD: begin
                    mem_cs     = 1'b1;
                    mem_addr   = held_addr;
                    mem_we     = held_we;
                    mem_seq    = 1'b0;
                    core_issue = 1'b1;
                end
                OWN_CORE, OWN_DMA: begin
                    mem_cs     = core_req;
                    mem_addr   = core_addr;
                    mem_we     = core_we & core_req;
                    mem_seq    = core_seq & core_req & ~nseq_flag;
                    core_issue = core_req;
                end
                default: begin
                    mem_cs     = 1'b0;
                    core_issue = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/tcm_nseq_tracker.sv
module tcm_nseq_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_access,
    input  logic core_issue,
    output logic nseq_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          nseq_flag <= 1'b0;
        else if (dma_access) nseq_flag <= 1'b1;
        else if (core_issue) nseq_flag <= 1'b0;
    end
endmodule

// File: rtl/tcm_dma_port_mux.sv
module tcm_dma_port_mux
    import tcm_dma_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_req,
    input  logic [AW-1:0] core_addr,
    input  logic          core_we,
    input  logic          core_seq,
    input  logic          core_idle,
    output logic          core_wait,
    output logic          force_nseq,
    input  logic          dma_en,
    input  logic          dma_cs,
    input  logic [AW-1:0] dma_addr,
    input  logic          dma_we,
    output logic          dma_illegal,
    output logic          mem_cs,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_seq
);
    port_own_e     state;
    logic [AW-1:0] held_addr;
    logic          held_we;
    logic          core_issue;
    logic          nseq_flag;

    tcm_port_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_en    (dma_en),
        .core_req  (core_req),
        .core_addr (core_addr),
        .core_we   (core_we),
        .state     (state),
        .held_addr (held_addr),
        .held_we   (held_we)
    );

    tcm_port_select #(.AW(AW)) u_sel (
        .state      (state),
        .dma_en     (dma_en),
        .dma_cs     (dma_cs),
        .dma_addr   (dma_addr),
        .dma_we     (dma_we),
        .core_req   (core_req),
        .core_addr  (core_addr),
        .core_we    (core_we),
        .core_seq   (core_seq),
        .held_addr  (held_addr),
        .held_we    (held_we),
        .nseq_flag  (nseq_flag),
        .mem_cs     (mem_cs),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_seq    (mem_seq),
        .core_issue (core_issue)
    );

    tcm_nseq_tracker u_nseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_access (dma_en & dma_cs),
        .core_issue (core_issue),
        .nseq_flag  (nseq_flag)
    );

    assign core_wait   = (state == CORE_HELD);
    assign force_nseq  = nseq_flag;
    assign dma_illegal = dma_en & ~dma_cs & ~core_idle;
endmodule

// File: rtl/tcm_dma_port_mux_chk.sv
module tcm_dma_port_mux_chk #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          core_req,
    input logic [AW-1:0] core_addr,
    input logic          core_we,
    input logic          core_seq,
    input logic          core_idle,
    input logic          core_wait,
    input logic          force_nseq,
    input logic          dma_en,
    input logic          dma_cs,
    input logic [AW-1:0] dma_addr,
    input logic          dma_we,
    input logic          dma_illegal,
    input logic          mem_cs,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          mem_seq
);
    assert_dma_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en |-> (mem_addr == dma_addr && mem_cs == dma_cs));

    assert_dma_seq_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en |-> !mem_seq);

    assert_illegal_no_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && !dma_cs && !core_idle) |-> (dma_illegal && !mem_cs));

    assert_wait_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && core_req && !core_wait) |=> core_wait);

    assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && core_wait) |=> core_wait);

    assert_held_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wait && !dma_en) |-> (mem_cs && !mem_seq));

    assert_wait_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wait && !dma_en) |=> !core_wait);

    assert_nseq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && dma_cs) |=> force_nseq);

    assert_nseq_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (force_nseq && mem_cs && !dma_en) |-> !mem_seq);
endmodule

bind tcm_dma_port_mux tcm_dma_port_mux_chk #(.AW(AW)) u_chk (.*);

// File: tb/tcm_dma_port_mux_bench.sv
module tcm_dma_port_mux_bench;
    localparam int AW = 18;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_req = 0, core_we = 0, core_seq = 0, core_idle = 1;
    logic [AW-1:0] core_addr = '0, dma_addr = '0;
    logic dma_en = 0, dma_cs = 0, dma_we = 0;
    logic core_wait, force_nseq, dma_illegal, mem_cs, mem_we, mem_seq;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    bit m_held = 0, m_hwe = 0, m_nseq = 0;
    logic [AW-1:0] m_haddr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcm_dma_port_mux #(.AW(AW)) u_tcm_dma_port_mux (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_addr(core_addr), .core_we(core_we),
        .core_seq(core_seq), .core_idle(core_idle),
        .core_wait(core_wait), .force_nseq(force_nseq),
        .dma_en(dma_en), .dma_cs(dma_cs), .dma_addr(dma_addr), .dma_we(dma_we),
        .dma_illegal(dma_illegal),
        .mem_cs(mem_cs), .mem_addr(mem_addr), .mem_we(mem_we), .mem_seq(mem_seq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model, then advance the model.
    task automatic compare_and_advance();
        bit e_cs, e_we, e_seq, issue;
        logic [AW-1:0] e_addr;
        string tag;
        if (dma_en) begin
            e_cs = dma_cs; e_addr = dma_addr; e_we = dma_we & dma_cs; e_seq = 0; tag = "R2";
        end else if (m_held) begin
            e_cs = 1; e_addr = m_haddr; e_we = m_hwe; e_seq = 0; tag = "R6";
        end else begin
            e_cs = core_req; e_addr = core_addr; e_we = core_we & core_req;
            e_seq = core_seq & core_req & !m_nseq; tag = "R7";
        end
        chk(tag, "mem_cs", mem_cs, e_cs);
        if (e_cs) chk(tag, "mem_addr", mem_addr, e_addr);
        chk(tag, "mem_we", mem_we, e_we);
        chk(dma_en ? "R3" : "R9", "mem_seq", mem_seq, e_seq);
        chk("R5", "core_wait", core_wait, m_held);
        chk("R8", "force_nseq", force_nseq, m_nseq);
        chk("R4", "dma_illegal", dma_illegal, dma_en & !dma_cs & !core_idle);
        issue = !dma_en && (m_held || core_req);
        if (dma_en && dma_cs) m_nseq = 1;
        else if (issue)       m_nseq = 0;
        if (!m_held && dma_en && core_req) begin
            m_haddr = core_addr; m_hwe = core_we;
        end
        m_held = dma_en && (m_held || core_req);
    endtask

    task automatic drive(input bit en, input bit cs, input bit dwe, input bit creq,
                         input bit cwe, input bit cseq, input bit legal_only);
        @(negedge clk);
        dma_en = en; dma_cs = cs; dma_we = dwe;
        dma_addr = AW'($urandom);
        core_addr = AW'($urandom);
        core_we = cwe; core_seq = cseq;
        // core only starts new requests when not waiting; idle follows request
        core_req = creq & !core_wait;
        if (legal_only && en && !cs) core_req = 0;
        core_idle = !core_req && !core_wait;
        #1;
        compare_and_advance();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk("R1", "mem_cs", mem_cs, 0);
        chk("R1", "core_wait", core_wait, 0);
        chk("R1", "force_nseq", force_nseq, 0);
        @(negedge clk);
        rst_n = 1;

        // Directed R5/R6/R8/R9: stall a core request across a 3-cycle DMA burst
        drive(0, 0, 0, 1, 0, 1, 1);        // plain core seq access, R7/R9
        drive(1, 1, 1, 1, 1, 0, 1);        // DMA writes, core request captured R5
        drive(1, 1, 0, 0, 0, 0, 1);
        drive(1, 0, 0, 0, 0, 0, 1);        // DMA enable without cs, core waiting
        drive(0, 0, 0, 1, 0, 1, 1);        // held request issued, live ignored R6
        drive(0, 0, 0, 1, 0, 1, 1);        // first live access after R9
        drive(0, 0, 0, 1, 0, 1, 1);        // seq passes once flag clear

        // Directed R4: enable without cs while core busy
        drive(0, 0, 0, 0, 0, 0, 1);
        drive(1, 0, 0, 1, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 1);
        drive(0, 0, 0, 0, 0, 0, 1);

        // Near-exhaustive sweep over the six control bits
        for (int round = 0; round < 40; round++) begin
            for (int p = 0; p < 64; p++) begin
                int q;
                q = (p * 37 + round * 11) % 64;
                drive(q[0], q[1], q[2], q[3], q[4], q[5], 1);
            end
        end

        // Mid-run reset returns the outputs to idle (R1)
        @(negedge clk);
        rst_n = 0;
        m_held = 0; m_nseq = 0;
        dma_en = 0; core_req = 0;
        #1;
        chk("R1", "mem_cs after reset", mem_cs, 0);
        chk("R1", "core_wait after reset", core_wait, 0);
        chk("R1", "force_nseq after reset", force_nseq, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule